// File: doc/BRIEF.md
# Peripheral Interrupt Flag Bank

This block holds the interrupt flags of one peripheral and turns them into a single interrupt request line. Pulses on the hardware event inputs raise flags. Software reads and controls the flags through four word registers on a simple 32-bit register bus. There is a flag view, a write-one-to-set alias, a write-one-to-clear alias and an enable mask. Each flag is gated by its enable bit, and the gated flags are ORed into a registered request output.

A mode input turns on atomic read-clear. In that mode a read of the clear alias returns the flag vector and, in the same access, clears exactly the bits it returned. A handler can therefore collect and acknowledge its pending sources in one bus access. A hardware event always takes priority over any clear in the same cycle, so an event is never lost.

The bus has one access per cycle with `bus_sel` high and `bus_wr` selecting write or read. Register index is taken from `bus_addr[3:2]`: 0 flag view, 1 set alias, 2 clear alias, 3 enable mask. Address bits 1:0 are ignored. Any higher address bit that is set makes the access miss. Read data is registered and appears on `bus_rdata` in the cycle after the access. It is zero in every cycle that follows no read.

Top module: `irq_flag_bank`

## Requirements
- R1: After reset every flag and every enable bit is 0, `irq` is low and `bus_rdata` is 0.
- R2: A 1 on `hw_evt[i]` at a clock edge sets flag i at that edge. The flag stays set until software clears it.
- R3: Writing the set alias (index 1) sets each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged. No flag rises without an event or a set-alias 1.
- R4: Writing the clear alias (index 2) clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R5: The enable mask (index 3) reads back what was last written in its low FLAG_W bits, with upper bits reading 0. Writes to the flag view (index 0) are ignored.
- R6: `irq` is the OR of (flag AND enable) over all bits, registered, so it follows a change of flags or enables one clock later.
- R7: With `rc_mode` = 1, a read of the clear alias returns the flag vector as it stood at the access and clears those flags.
- R8: With `rc_mode` = 0, a read of the clear alias returns 0 and leaves the flags unchanged. A read of the set alias also returns 0.
- R9: When a hardware event and a software clear or a read-clear hit the same flag in one cycle, the flag ends set. An event arriving during a read-clear stays pending.
- R10: Read data appears in the cycle after the read access and returns to 0 in the following cycle when no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address; bits 3:2 pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rc_mode | input | 1 | 1 enables atomic read-clear on the clear alias |
| hw_evt | input | FLAG_W | Hardware event pulses, one per flag |
| irq | output | 1 | Registered interrupt request |

## Verification
Some properties are checked on every cycle. Every event bit is set one edge later. No flag rises without an event or a set-alias 1. The request line matches the previous cycle's masked OR. A read-clear returns the prior vector and drops those bits unless they were re-raised. A plain read of the clear alias returns zero and leaves the flags alone. The bench scenarios cover the rest. They include full sweeps of all set and clear patterns with rotating enable masks, enable readback with the upper bits cut off, ignored writes to the flag view, and the exact cycle on which `irq` rises. They also make an event collide with a clear write and with a read-clear, where only the final flag state at the ports shows that the event won.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int BUS_W = 32;

  typedef enum logic [1:0] {
    REG_VIEW  = 2'd0,
    REG_SET   = 2'd1,
    REG_CLEAR = 2'd2,
    REG_MASK  = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_flag_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int FLAG_W = 8
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              rc_mode,
  output logic [FLAG_W-1:0] set_mask,
  output logic [FLAG_W-1:0] clr_mask,
  output logic              ien_we,
  output logic [FLAG_W-1:0] ien_wdata,
  output logic              ifc_rd,
  output logic              rc_fire,
  output logic              rd_en,
  output reg_idx_e          rd_idx
);
  logic     hit;
  reg_idx_e idx;

  assign idx = reg_idx_e'(bus_addr[3:2]);

  if (ADDR_W > 4) begin : g_hi_addr
    assign hit = bus_sel && (bus_addr[ADDR_W-1:4] == '0);
  end else begin : g_no_hi_addr
    assign hit = bus_sel;
  end

  logic unused_lo_addr;
  assign unused_lo_addr = ^bus_addr[1:0];

  if (FLAG_W < BUS_W) begin : g_pad
    logic unused_hi_data;
    assign unused_hi_data = ^bus_wdata[BUS_W-1:FLAG_W];
  end

  always_comb begin
    set_mask  = '0;
    clr_mask  = '0;
    ien_we    = 1'b0;
    ien_wdata = bus_wdata[FLAG_W-1:0];
    if (hit && bus_wr) begin
      unique case (idx)
        REG_SET:   set_mask = bus_wdata[FLAG_W-1:0];
        REG_CLEAR: clr_mask = bus_wdata[FLAG_W-1:0];
        REG_MASK:  ien_we   = 1'b1;
        default:   ;
      endcase
    end
  end

  assign rd_en   = hit && !bus_wr;
  assign rd_idx  = idx;
  assign ifc_rd  = rd_en && (idx == REG_CLEAR);
  assign rc_fire = ifc_rd && rc_mode;
endmodule

// File: rtl/irq_flag_cells.sv
module irq_flag_cells #(
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_W-1:0] hw_evt,
  input  logic [FLAG_W-1:0] set_mask,
  input  logic [FLAG_W-1:0] clr_mask,
  input  logic              rc_fire,
  output logic [FLAG_W-1:0] flag_q
);
  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    logic kill;
    // a read-clear drops only a bit it returned; raising terms come last so they win
    assign kill = clr_mask[i] | (rc_fire & flag_q[i]);

    always_ff @(posedge clk) begin
      if (rst)
        flag_q[i] <= 1'b0;
      else
        flag_q[i] <= hw_evt[i] | set_mask[i] | (flag_q[i] & ~kill);
    end
  end
endmodule

// File: rtl/irq_line_reg.sv
module irq_line_reg #(
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ien_we,
  input  logic [FLAG_W-1:0] ien_wdata,
  input  logic [FLAG_W-1:0] flag_q,
  output logic [FLAG_W-1:0] ien_q,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q <= '0;
      irq   <= 1'b0;
    end else begin
      if (ien_we)
        ien_q <= ien_wdata;
      irq <= |(flag_q & ien_q);
    end
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_flag_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rc_mode,
  input  logic [FLAG_W-1:0] hw_evt,
  output logic              irq
);
  logic [FLAG_W-1:0] set_mask;
  logic [FLAG_W-1:0] clr_mask;
  logic              ien_we;
  logic [FLAG_W-1:0] ien_wdata;
  logic              ifc_rd;
  logic              rc_fire;
  logic              rd_en;
  reg_idx_e          rd_idx;
  logic [FLAG_W-1:0] flag_q;
  logic [FLAG_W-1:0] ien_q;

  irq_bus_decode #(.ADDR_W(ADDR_W), .FLAG_W(FLAG_W)) u_dec (
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rc_mode   (rc_mode),
    .set_mask  (set_mask),
    .clr_mask  (clr_mask),
    .ien_we    (ien_we),
    .ien_wdata (ien_wdata),
    .ifc_rd    (ifc_rd),
    .rc_fire   (rc_fire),
    .rd_en     (rd_en),
    .rd_idx    (rd_idx)
  );

  irq_flag_cells #(.FLAG_W(FLAG_W)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .hw_evt   (hw_evt),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .rc_fire  (rc_fire),
    .flag_q   (flag_q)
  );

  irq_line_reg #(.FLAG_W(FLAG_W)) u_line (
    .clk       (clk),
    .rst       (rst),
    .ien_we    (ien_we),
    .ien_wdata (ien_wdata),
    .flag_q    (flag_q),
    .ien_q     (ien_q),
    .irq       (irq)
  );

  logic [BUS_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (rd_en) begin
      unique case (rd_idx)
        REG_VIEW:  rd_mux = BUS_W'(flag_q);
        REG_CLEAR: rd_mux = rc_mode ? BUS_W'(flag_q) : '0;
        REG_MASK:  rd_mux = BUS_W'(ien_q);
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else
      bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_flag_bank_chk.sv
module irq_flag_bank_chk #(
  parameter int FLAG_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [FLAG_W-1:0] hw_evt,
  input logic [FLAG_W-1:0] set_mask,
  input logic              ifc_rd,
  input logic              rc_mode,
  input logic [FLAG_W-1:0] flag_q,
  input logic [FLAG_W-1:0] ien_q,
  input logic              irq,
  input logic [31:0]       bus_rdata
);
  // R2 and R9: an event bit is set one edge later, whatever clear came with it
  assert_event_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (|hw_evt) |=> ((flag_q & $past(hw_evt)) == $past(hw_evt)));

  assert_no_spurious_rise_R3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((flag_q & ~$past(flag_q) & ~$past(hw_evt) & ~$past(set_mask)) == '0));

  assert_irq_registered_R6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq == $past(|(flag_q & ien_q))));

  assert_read_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (ifc_rd && rc_mode) |=> ((bus_rdata == 32'($past(flag_q))) &&
                             ((flag_q & $past(flag_q) & ~$past(hw_evt)) == '0)));

  assert_plain_clear_read_R8: assert property (@(posedge clk) disable iff (rst)
    (ifc_rd && !rc_mode) |=> ((bus_rdata == 32'd0) &&
                              (flag_q == ($past(flag_q) | $past(hw_evt)))));
endmodule

bind irq_flag_bank irq_flag_bank_chk #(.FLAG_W(FLAG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hw_evt    (hw_evt),
  .set_mask  (set_mask),
  .ifc_rd    (ifc_rd),
  .rc_mode   (rc_mode),
  .flag_q    (flag_q),
  .ien_q     (ien_q),
  .irq       (irq),
  .bus_rdata (bus_rdata)
);

// File: tb/sim_irq_flag_bank.sv
module sim_irq_flag_bank;
  localparam int FW = 8;
  localparam logic [3:0] A_VIEW = 4'h0, A_SET = 4'h4, A_CLR = 4'h8, A_MASK = 4'hC;
  localparam logic [31:0] ALL = 32'hFF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          rc_mode = 1'b0;
  logic [FW-1:0] hw_evt = '0;
  logic          irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_flag_bank #(.ADDR_W(4), .FLAG_W(FW)) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rc_mode(rc_mode), .hw_evt(hw_evt), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic pulse(input logic [FW-1:0] e);
    @(negedge clk);
    hw_evt = e;
    @(negedge clk);
    hw_evt = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 rdata", bus_rdata, 32'd0);
    rd(A_VIEW, d); check("R1 flags", d, 32'd0);
    rd(A_MASK, d); check("R1 mask", d, 32'd0);

    // R3 and R6 sweep of set patterns with rotating masks
    for (int v = 0; v < 256; v++) begin
      logic [31:0] m;
      m = ((v * 37) ^ 32'h5A) & ALL;
      wr(A_CLR, ALL);
      wr(A_SET, 32'(v));
      wr(A_MASK, m);
      rd(A_VIEW, d);
      check("R3 set sweep", d, 32'(v));
      check("R6 irq sweep", {31'd0, irq}, {31'd0, |(v[7:0] & m[7:0])});
    end

    // R4 sweep of clear patterns
    for (int v = 0; v < 256; v++) begin
      wr(A_SET, ALL);
      wr(A_CLR, 32'(v));
      rd(A_VIEW, d);
      check("R4 clear sweep", d, ~32'(v) & ALL);
    end

    // R5 mask readback and ignored flag-view writes
    wr(A_MASK, 32'h96); rd(A_MASK, d); check("R5 mask", d, 32'h96);
    wr(A_MASK, 32'hFFFF_FFFF); rd(A_MASK, d); check("R5 mask upper", d, ALL);
    wr(A_CLR, ALL);
    wr(A_VIEW, ALL); rd(A_VIEW, d); check("R5 view write ignored", d, 32'd0);

    // R2 event sets and holds; R6 one-cycle latency
    wr(A_MASK, 32'h01);
    @(negedge clk);
    check("R6 idle irq", {31'd0, irq}, 32'd0);
    pulse(8'h01);
    check("R6 irq not yet", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R6 irq raised", {31'd0, irq}, 32'd1);
    pulse(8'h40);
    repeat (3) @(negedge clk);
    rd(A_VIEW, d); check("R2 event held", d, 32'h41);
    wr(A_MASK, 32'h00);
    @(negedge clk);
    check("R6 masked off", {31'd0, irq}, 32'd0);

    // R8 plain read of the clear alias, R10 return to zero
    wr(A_CLR, ALL); wr(A_SET, 32'h3C);
    rc_mode = 1'b0;
    rd(A_CLR, d); check("R8 clear read zero", d, 32'd0);
    rd(A_VIEW, d); check("R8 flags kept", d, 32'h3C);
    rd(A_SET, d); check("R8 set read zero", d, 32'd0);
    rd(A_VIEW, d);
    @(negedge clk);
    check("R10 rdata idle", bus_rdata, 32'd0);

    // R7 read-clear
    wr(A_CLR, ALL); wr(A_SET, 32'hA5);
    rc_mode = 1'b1;
    rd(A_CLR, d); check("R7 rc returns", d, 32'hA5);
    rd(A_VIEW, d); check("R7 rc cleared", d, 32'd0);

    // R9 event collides with clear write
    rc_mode = 1'b0;
    wr(A_SET, ALL);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = ALL; hw_evt = 8'h10;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; hw_evt = '0;
    rd(A_VIEW, d); check("R9 set beats clear", d, 32'h10);

    // R9 event during read-clear
    wr(A_CLR, ALL); wr(A_SET, 32'h0F);
    rc_mode = 1'b1;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_CLR; hw_evt = 8'h81;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0; hw_evt = '0;
    check("R9 rc returns", d, 32'h0F);
    rd(A_VIEW, d); check("R9 event kept through rc", d, 32'h81);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule